// File: doc/BRIEF.md
# Pulse-Length Coded Field Modulator

This block produces the carrier-enable waveform that a low-frequency reader uses to send a command to a tag. The reader's antenna field is switched fully on and off (100% amplitude keying), and every bit is a short field-off gap followed by a field-on period. The length of that field-on period gives the bit value. Time is counted in units of 8 microseconds. One unit passes on each clock cycle in which the `unit_tick` clock-enable input is high.

A frame begins when `start` is pulsed with a nonzero bit count. The field first stays on for a long lead-in period. The command bits follow, most significant first. A terminator ends the frame: a gap, then a field-on period longer than any bit. After the frame the field stays on so that the tag stays powered. `done` is high for one clock and `busy` falls.

The controller is a state machine with six named states:
- `ST_IDLE`: the field holds its last level.
- `ST_LEAD`: lead-in, field on.
- `ST_GAP`: bit gap, field off.
- `ST_MARK`: bit mark, field on.
- `ST_EOF_GAP`: terminator gap, field off.
- `ST_EOF_MARK`: terminator mark, field on.

The transitions are:
- IDLE→LEAD when a strobe is accepted.
- LEAD→GAP when the lead-in expires.
- GAP→MARK when the gap expires.
- MARK→GAP when a mark expires and bits remain.
- MARK→EOF_GAP when the mark of the last bit expires.
- EOF_GAP→EOF_MARK when the terminator gap expires.
- EOF_MARK→IDLE when the terminator mark expires. This transition raises `done`.

Top module: `plc_field_mod`

## Requirements
- R1: After reset, `field_en`, `busy` and `done` are all low.
- R2: A `start` pulse in idle with a nonzero `bit_count` is accepted. `busy` is high from the next clock. The field is then on for 170 units. A unit is a cycle with `unit_tick` high, and a tick in the accepting cycle itself is not counted.
- R3: Each bit is 8 units with the field off. The field is then on for 18 units for a 0 bit or 28 units for a 1 bit.
- R4: The bits sent are `cmd_word[bit_count-1]` down to `cmd_word[0]`, in that order. For example, the 5-bit get-UID code 00110 (`cmd_word`=6, `bit_count`=5) goes out as 0,0,1,1,0.
- R5: After the last bit, the field is off for 8 units and then on for 38 units. In the clock after the final unit, `done` is high for exactly one cycle and `busy` is low.
- R6: Once a frame has ended, `field_en` stays high while the block is idle.
- R7: A `start` with `bit_count` of 0 sends nothing. There is no lead-in, `busy` stays low, `done` stays low, and `field_en` keeps its level.
- R8: A `start` that arrives while `busy` is high is ignored. The frame in progress continues unchanged.
- R9: A `bit_count` above `MAX_BITS` (32) is treated as `MAX_BITS`.
- R10: `field_en` changes only on the clock edge that ends a tick cycle, or on the edge that accepts a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_tick | input | 1 | Clock enable, one cycle per 8 µs time unit |
| start | input | 1 | Frame strobe |
| cmd_word | input | 32 | Command bits, right-aligned |
| bit_count | input | 6 | Number of command bits to send |
| field_en | output | 1 | Carrier-enable to the antenna driver |
| busy | output | 1 | High while a frame is in progress |
| done | output | 1 | One-cycle pulse after the terminator |

## Verification
After a strobe is accepted, `busy` is due in the next clock. Each segment then ends on the edge of its last tick cycle, so the field level during tick k is sampled at the falling clock edge inside that tick cycle. For every tick, the bench compares that level with a level it computes by walking the segment durations. `done` is due exactly one clock after the final tick of the terminator. The bench samples it at the next falling edge and checks that it has dropped one edge later. The bench sweeps every pattern of 1 to 4 bits and also sends the get-UID code, a full 32-bit word, an over-range count, strobes during a frame, and zero-count strobes.

// File: rtl/plc_field_pkg.sv
package plc_field_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_GAP,
        ST_MARK,
        ST_EOF_GAP,
        ST_EOF_MARK
    } plc_state_e;

endpackage

// File: rtl/plc_unit_timer.sv
module plc_unit_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] rem_q;

    // A load takes priority, so a tick in the loading cycle is not counted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (tick && rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign expire = tick && (rem_q == CNT_W'(1));
endmodule

// File: rtl/plc_bit_sel.sv
module plc_bit_sel #(
    parameter int MAX_BITS = 32,
    parameter int CNT_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [MAX_BITS-1:0] word,
    input  logic [CNT_W-1:0]    count,
    input  logic                advance,
    output logic                cur_bit,
    output logic                last_bit
);
    localparam int IDX_W = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

    logic [MAX_BITS-1:0] word_q;
    logic [IDX_W-1:0]    idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            word_q <= word;
            idx_q  <= IDX_W'(count - 1'b1);
        end else if (advance && idx_q != '0) begin
            idx_q  <= idx_q - 1'b1;
        end
    end

    assign cur_bit  = word_q[idx_q];
    assign last_bit = (idx_q == '0);
endmodule

// File: rtl/plc_field_mod.sv
module plc_field_mod
    import plc_field_pkg::*;
#(
    parameter int MAX_BITS = 32,
    parameter int LEAD_U   = 170,
    parameter int GAP_U    = 8,
    parameter int ZERO_U   = 18,
    parameter int ONE_U    = 28,
    parameter int EOF_U    = 38,
    parameter int DUR_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              unit_tick,
    input  logic                              start,
    input  logic [MAX_BITS-1:0]               cmd_word,
    input  logic [$clog2(MAX_BITS+1)-1:0]     bit_count,
    output logic                              field_en,
    output logic                              busy,
    output logic                              done
);
    localparam int CW = $clog2(MAX_BITS + 1);
    localparam logic [CW-1:0]    MAX_CNT = CW'(MAX_BITS);
    localparam logic [DUR_W-1:0] D_LEAD  = DUR_W'(LEAD_U);
    localparam logic [DUR_W-1:0] D_GAP   = DUR_W'(GAP_U);
    localparam logic [DUR_W-1:0] D_ZERO  = DUR_W'(ZERO_U);
    localparam logic [DUR_W-1:0] D_ONE   = DUR_W'(ONE_U);
    localparam logic [DUR_W-1:0] D_EOF   = DUR_W'(EOF_U);

    plc_state_e       state_q, state_d;
    logic [CW-1:0]    eff_cnt;
    logic             accept;
    logic             t_load;
    logic [DUR_W-1:0] t_val;
    logic             t_expire;
    logic             b_adv;
    logic             cur_bit;
    logic             last_bit;
    logic             finish;
    logic             hold_q;
    logic             done_q;

    // Counts beyond the word width are clamped to it.
    assign eff_cnt = (bit_count > MAX_CNT) ? MAX_CNT : bit_count;
    assign accept  = (state_q == ST_IDLE) && start && (eff_cnt != '0);

    plc_unit_timer #(.CNT_W(DUR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (unit_tick),
        .load     (t_load),
        .load_val (t_val),
        .expire   (t_expire)
    );

    plc_bit_sel #(.MAX_BITS(MAX_BITS), .CNT_W(CW)) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .word     (cmd_word),
        .count    (eff_cnt),
        .advance  (b_adv),
        .cur_bit  (cur_bit),
        .last_bit (last_bit)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state, timer reload and bit advance
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = D_GAP;
        b_adv   = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_LEAD;
                    t_load  = 1'b1;
                    t_val   = D_LEAD;
                end
            end
            ST_LEAD: begin
                if (t_expire) begin
                    state_d = ST_GAP;
                    t_load  = 1'b1;
                    t_val   = D_GAP;
                end
            end
            ST_GAP: begin
                if (t_expire) begin
                    state_d = ST_MARK;
                    t_load  = 1'b1;
                    t_val   = cur_bit ? D_ONE : D_ZERO;
                end
            end
            ST_MARK: begin
                if (t_expire) begin
                    t_load = 1'b1;
                    t_val  = D_GAP;
                    if (last_bit) begin
                        state_d = ST_EOF_GAP;
                    end else begin
                        state_d = ST_GAP;
                        b_adv   = 1'b1;
                    end
                end
            end
            ST_EOF_GAP: begin
                if (t_expire) begin
                    state_d = ST_EOF_MARK;
                    t_load  = 1'b1;
                    t_val   = D_EOF;
                end
            end
            ST_EOF_MARK: begin
                if (t_expire) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Idle field level and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) begin
                hold_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:     field_en = hold_q;
            ST_LEAD:     field_en = 1'b1;
            ST_GAP:      field_en = 1'b0;
            ST_MARK:     field_en = 1'b1;
            ST_EOF_GAP:  field_en = 1'b0;
            ST_EOF_MARK: field_en = 1'b1;
            default:     field_en = 1'b0;
        endcase
        busy = (state_q != ST_IDLE);
        done = done_q;
    end
endmodule

// File: rtl/plc_field_mod_chk.sv
module plc_field_mod_chk #(
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          unit_tick,
    input logic          start,
    input logic [CW-1:0] bit_count,
    input logic          field_en,
    input logic          busy,
    input logic          done
);
    // R7
    zero_cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && bit_count == '0) |=> !busy);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_field_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (field_en && !busy));

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(start) && $past(bit_count) != '0));

    // R5
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10
    field_edge_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_en) |-> ($past(unit_tick) || $rose(busy)));
endmodule

bind plc_field_mod plc_field_mod_chk #(.CW($clog2(MAX_BITS + 1))) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .unit_tick (unit_tick),
    .start     (start),
    .bit_count (bit_count),
    .field_en  (field_en),
    .busy      (busy),
    .done      (done)
);

// File: tb/plc_field_mod_test.sv
module plc_field_mod_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        unit_tick = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [5:0]  bit_count = '0;
    logic        field_en, busy, done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    plc_field_mod uut (
        .clk(clk), .rst_n(rst_n), .unit_tick(unit_tick), .start(start),
        .cmd_word(cmd_word), .bit_count(bit_count),
        .field_en(field_en), .busy(busy), .done(done)
    );

    // One tick in four cycles, changed just after the rising edge.
    initial begin
        int div = 0;
        forever begin
            @(posedge clk);
            #1;
            div = (div + 1) % 4;
            unit_tick = (div == 0);
        end
    end

    function automatic int frame_len(input logic [31:0] w, input int n);
        int t = 170;
        for (int i = n - 1; i >= 0; i--) t += 8 + (w[i] ? 28 : 18);
        return t + 46;
    endfunction

    function automatic logic exp_lvl(input logic [31:0] w, input int n, input int k);
        int p = k;
        if (p <= 170) return 1'b1;
        p -= 170;
        for (int i = n - 1; i >= 0; i--) begin
            int d = w[i] ? 28 : 18;
            if (p <= 8) return 1'b0;
            p -= 8;
            if (p <= d) return 1'b1;
            p -= d;
        end
        if (p <= 8) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sends a frame; n_eff is the count after clamping. inject: strobe mid-frame.
    task automatic run_frame(input logic [31:0] w, input int n_in, input int n_eff, input bit inject);
        int total = frame_len(w, n_eff);
        int k = 0;
        int mism = 0, first_k = -1, first_act = 0;
        int bad_busy = 0, early_done = 0;
        bit injected = 0;
        @(negedge clk);
        cmd_word = w; bit_count = 6'(n_in); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2 busy after strobe", busy, 1);
        forever begin
            if (start) start = 1'b0;
            if (busy !== 1'b1) bad_busy++;
            if (done !== 1'b0) early_done++;
            if (unit_tick) begin
                k++;
                if (field_en !== exp_lvl(w, n_eff, k)) begin
                    mism++;
                    if (first_k < 0) begin first_k = k; first_act = field_en; end
                end
                if (k == total) break;
            end
            if (inject && !injected && k == 100) begin
                injected = 1;
                start = 1'b1; cmd_word = ~w; bit_count = 6'd3;
            end
            @(negedge clk);
        end
        // R2 R3 R4 R5 R8 R9: waveform per unit
        check(mism == 0, $sformatf("R3/R4 waveform n=%0d w=%h unit %0d", n_eff, w, first_k),
              first_act, first_k < 0 ? 0 : int'(exp_lvl(w, n_eff, first_k)));
        check(bad_busy == 0 && early_done == 0, "R5 busy held, no early done", bad_busy + early_done, 0);
        @(negedge clk);
        check(done === 1'b1 && busy === 1'b0 && field_en === 1'b1, "R5 done after terminator",
              {done, busy, field_en}, 3'b101);
        @(negedge clk);
        check(done === 1'b0, "R5 done one cycle", done, 0);
        for (int i = 0; i < 6; i++) begin
            if (field_en !== 1'b1 || busy !== 1'b0) mism++;
            @(negedge clk);
        end
        check(mism == 0, "R6 field held on when idle", mism, 0);
    endtask

    task automatic zero_strobe(input logic lvl);
        int bad = 0;
        @(negedge clk);
        cmd_word = 32'hFFFF_FFFF; bit_count = 6'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (busy !== 1'b0 || done !== 1'b0 || field_en !== lvl) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R7 zero count sends nothing", bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(field_en === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 reset state",
              {field_en, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(field_en === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 idle after reset",
              {field_en, busy, done}, 0);
        zero_strobe(1'b0);
        // R4 get-UID code 00110
        run_frame(32'h6, 5, 5, 1'b0);
        zero_strobe(1'b1);
        // R3 R4 sweep of all short patterns
        for (int n = 1; n <= 4; n++)
            for (int v = 0; v < (1 << n); v++)
                run_frame(32'(v), n, n, 1'b0);
        // R8 strobe during a frame is ignored
        run_frame(32'h5, 3, 3, 1'b1);
        run_frame(32'hA5C3_0F96, 32, 32, 1'b1);
        // R9 over-range count clamps to 32
        run_frame(32'h8000_0001, 40, 32, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule